// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block is a combinational arithmetic and logic unit for a datapath of configurable width (8, 16 or 32 bits). It takes two operands, a three-bit operation code and a carry-in. From these it produces a result and a six-bit flag vector in the same cycle. The supported operations are add, add with carry, subtract, subtract with borrow, and bitwise AND, OR and XOR.

The flag vector reports unsigned range errors (carry), signed range errors (overflow), the sign and zero state of the result, the carry or borrow between bit 3 and bit 4 (auxiliary carry), and the even parity of the low byte of the result.

A status register stage can be selected by parameter. When present, it latches the flag vector on a clock edge where the write enable is high. It holds its value at all other edges.

Top module: `flag_alu`

## Requirements
- R1: Operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 clear. For code 0 the result is (a+b) mod 2^WIDTH. For code 1 the result is (a+b+cin) mod 2^WIDTH.
- R2: For code 2 the result is (a-b) mod 2^WIDTH. For code 3 the result is (a-b-cin) mod 2^WIDTH.
- R3: The carry flag is flags[0]. For codes 0 and 1 it is set when the true unsigned sum is at least 2^WIDTH. For codes 2 and 3 it is set when the unsigned difference a-b (minus cin for code 3) is negative, which is a borrow.
- R4: The overflow flag is flags[5]. For codes 0 and 1 it is set when a and b have the same sign bit and the result sign differs from it. For codes 2 and 3 it is set when a and b have different sign bits and the result sign differs from a's sign bit.
- R5: The sign flag is flags[4] and equals the most significant result bit. The zero flag is flags[3] and is set when every result bit is zero.
- R6: The auxiliary carry flag is flags[2]. For codes 0 and 1 it is set when the low 4 bits of a, plus the low 4 bits of b, plus the included carry-in, exceed 15. For codes 2 and 3 it is set when the low-4-bit difference, with the included borrow, is negative.
- R7: The parity flag is flags[1]. It is set when result bits 7 down to 0 contain an even number of ones, whatever the width.
- R8: Codes 4, 5 and 6 give a&b, a|b and a^b, and code 7 gives a zero result. For codes 4 to 7 the carry, overflow and auxiliary carry flags are 0.
- R9: cin has no effect on the result or flags for codes 0, 2 and 4 to 7.
- R10: With the status stage enabled, stat_q is 0 after reset. stat_q takes the flag vector at a rising clock edge where flag_we is 1, and holds its value at every edge where flag_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 3 | Operation code |
| cin | input | 1 | Carry or borrow input |
| flag_we | input | 1 | Status register write enable |
| result | output | WIDTH | Operation result |
| flags | output | 6 | Flag vector {overflow, sign, zero, aux, parity, carry} |
| stat_q | output | 6 | Registered flag vector |

## Verification
Every value of a is paired with a set of b values. This set contains the nibble and sign boundaries (0, 1, 0x0F, 0x10, 0x7F, 0x80, 0xFE, 0xFF) and a spread of values between them. Each pair is run under all eight codes and both carry-in levels.

The boundary values separate the carry from the overflow, and the auxiliary carry from the full carry. They also give exact zero results that set the zero flag. Running with cin both high and low checks two things: it is included in the codes that use it, and it has no effect elsewhere. A short clocked sequence loads the status register, then changes the inputs with the enable low to check that the register holds.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CLR = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             aux,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [WIDTH:0]   full;

    // Subtraction is a + ~b + 1 - borrow_in; the carry out is then inverted into a borrow.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
        sum   = full[MSB:0];
        carry = full[WIDTH] ^ sub;
        aux   = a[4] ^ b_eff[4] ^ full[4] ^ sub;
        ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]          a,
    input  logic [WIDTH-1:0]          b,
    input  flag_alu_pkg::alu_op_e     op,
    output logic [WIDTH-1:0]          res
);
    import flag_alu_pkg::*;

    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]           res,
    input  logic                       arith,
    input  logic                       carry,
    input  logic                       aux,
    input  logic                       ovf,
    output flag_alu_pkg::alu_flags_t   flags
);
    always_comb begin
        flags.carry  = arith & carry;
        flags.ovf    = arith & ovf;
        flags.aux    = arith & aux;
        flags.sign   = res[WIDTH-1];
        flags.zero   = (res == '0);
        flags.parity = ~^res[7:0];
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  flag_alu_pkg::alu_flags_t  flags_in,
    output flag_alu_pkg::alu_flags_t  stat_q
);
    import flag_alu_pkg::*;

    typedef struct packed {
        alu_flags_t stat;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.stat = flags_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_q = state_q.stat;
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
    parameter int WIDTH    = 8,
    parameter bit STAT_REG = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WIDTH-1:0]                a,
    input  logic [WIDTH-1:0]                b,
    input  logic [2:0]                      op,
    input  logic                            cin,
    input  logic                            flag_we,
    output logic [WIDTH-1:0]                result,
    output logic [flag_alu_pkg::FLAG_W-1:0] flags,
    output logic [flag_alu_pkg::FLAG_W-1:0] stat_q
);
    import flag_alu_pkg::*;

    typedef struct packed {
        logic             arith;
        logic             sub;
        logic             cin_used;
        logic [WIDTH-1:0] res;
    } dp_t;

    alu_op_e          op_e;
    dp_t              dp_d;
    logic [WIDTH-1:0] arith_sum, logic_res;
    logic             arith_c, arith_ac, arith_v;
    alu_flags_t       flags_d, stat_s;

    assign op_e = alu_op_e'(op);

    always_comb begin
        dp_d          = '0;
        dp_d.arith    = (op_e inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB});
        dp_d.sub      = (op_e inside {OP_SUB, OP_SBB});
        dp_d.cin_used = cin && (op_e inside {OP_ADC, OP_SBB});
        dp_d.res      = dp_d.arith ? arith_sum : logic_res;
    end

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a(a), .b(b), .sub(dp_d.sub), .cin(dp_d.cin_used),
        .sum(arith_sum), .carry(arith_c), .aux(arith_ac), .ovf(arith_v)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a), .b(b), .op(op_e), .res(logic_res)
    );

    alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .res(dp_d.res), .arith(dp_d.arith), .carry(arith_c),
        .aux(arith_ac), .ovf(arith_v), .flags(flags_d)
    );

    generate
        if (STAT_REG) begin : g_stat
            alu_status_reg u_stat (
                .clk(clk), .rst_n(rst_n), .we(flag_we),
                .flags_in(flags_d), .stat_q(stat_s)
            );
        end else begin : g_nostat
            assign stat_s = '0;
        end
    endgenerate

    assign result = dp_d.res;
    assign flags  = flags_d;
    assign stat_q = stat_s;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int WIDTH    = 8,
    parameter bit STAT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [2:0]       op,
    input logic             flag_we,
    input logic [WIDTH-1:0] result,
    input logic [5:0]       flags,
    input logic [5:0]       stat_q
);
    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |-> ({flags[0], result} == ({1'b0, a} + {1'b0, b})));

    assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op[2]) |-> (!flags[0] && !flags[5] && !flags[2]));

    assert_sign_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flags[4] == result[WIDTH-1]);

    assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] == ~^result[7:0]);

    generate
        if (STAT_REG) begin : g_stat_chk
            assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
                flag_we |=> (stat_q == $past(flags)));
            assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !flag_we |=> $stable(stat_q));
        end
    endgenerate
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH), .STAT_REG(STAT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .flag_we(flag_we),
    .result(result), .flags(flags), .stat_q(stat_q)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [2:0]   op = '0;
    logic         cin = 1'b0, flag_we = 1'b0;
    logic [W-1:0] result;
    logic [5:0]   flags, stat_q;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flag_alu #(.WIDTH(W), .STAT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .cin(cin),
        .flag_we(flag_we), .result(result), .flags(flags), .stat_q(stat_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s a=%0h b=%0h op=%0d cin=%0b actual=%0h expected=%0h",
                     req, a, b, op, cin, act, exp);
        end
    endtask

    // Returns {flags[5:0], result[7:0]} from the requirement arithmetic.
    function automatic logic [13:0] model(input int av, input int bv, input int o, input int c);
        int r, ce, cf, af, vf, ones;
        int a7, b7, r7;
        ce = (o == 1 || o == 3) ? c : 0;
        cf = 0; af = 0; vf = 0;
        a7 = (av >> 7) & 1; b7 = (bv >> 7) & 1;
        case (o)
            0, 1: begin
                r  = av + bv + ce;
                cf = (r > 255);
                af = ((av & 15) + (bv & 15) + ce) > 15;
                r  = r & 255; r7 = (r >> 7) & 1;
                vf = (a7 == b7) && (r7 != a7);
            end
            2, 3: begin
                r  = av - bv - ce;
                cf = (r < 0);
                af = ((av & 15) - (bv & 15) - ce) < 0;
                r  = r & 255; r7 = (r >> 7) & 1;
                vf = (a7 != b7) && (r7 != a7);
            end
            4: r = av & bv;
            5: r = av | bv;
            6: r = av ^ bv;
            default: r = 0;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        model = {vf[0], r[7], (r == 0), af[0], ((ones % 2) == 0), cf[0], r[7:0]};
    endfunction

    function automatic int bval(input int j);
        int sp[8] = '{0, 1, 15, 16, 127, 128, 254, 255};
        if (j < 8) return sp[j];
        return ((j - 8) * 23 + 5) & 255;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [13:0] e;
        logic [5:0]  saved;
        // R10: reset state
        #7;
        chk(stat_q == 6'h00, "R10 reset", stat_q, 0);
        @(negedge clk); rst_n = 1'b1;

        // Sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int ai = 0; ai < 256; ai++) begin
            for (int j = 0; j < 20; j++) begin
                for (int o = 0; o < 8; o++) begin
                    for (int c = 0; c < 2; c++) begin
                        a = ai[7:0]; b = bval(j); op = o[2:0]; cin = c[0];
                        #1;
                        e = model(ai, bval(j), o, c);
                        chk(result == e[7:0], (o < 2) ? "R1 result" : (o < 4) ? "R2 result" : "R8 result",
                            result, e[7:0]);
                        chk(flags[0] == e[8],  "R3 carry",  flags[0], e[8]);
                        chk(flags[5] == e[13], "R4 overflow", flags[5], e[13]);
                        chk(flags[4:3] == e[12:11], "R5 sign/zero", flags[4:3], e[12:11]);
                        chk(flags[2] == e[10], "R6 aux", flags[2], e[10]);
                        chk(flags[1] == e[9],  "R7 parity", flags[1], e[9]);
                        if (o != 1 && o != 3)
                            chk({flags, result} == e, "R9 cin ignored", {flags, result}, e);
                    end
                end
            end
        end

        // R10: capture and hold
        @(negedge clk);
        a = 8'h7f; b = 8'h01; op = 3'd0; cin = 1'b0; flag_we = 1'b1;
        e = model(127, 1, 0, 0);
        @(negedge clk);
        flag_we = 1'b0;
        chk(stat_q == e[13:8], "R10 capture", stat_q, e[13:8]);
        saved = e[13:8];
        a = 8'h00; b = 8'h00; op = 3'd4;
        @(negedge clk); @(negedge clk);
        chk(stat_q == saved, "R10 hold", stat_q, saved);
        a = 8'h10; b = 8'h01; op = 3'd3; cin = 1'b1; flag_we = 1'b1;
        e = model(16, 1, 3, 1);
        @(negedge clk);
        flag_we = 1'b0;
        chk(stat_q == e[13:8], "R10 capture sbb", stat_q, e[13:8]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule